// File: doc/BRIEF.md
# Predicated Mixed-Width Vector Add Sequencer

This block steps a vector add across a run of elements. The elements live in an external register file that can be viewed at several element sizes. Each of the three operand registers carries its own element-width code and a flag marking it as a vector or a scalar. A predicate mask chooses which elements are computed. For every enabled element, the sequencer reads both sources through their own width views and widens each one to the larger of the two source widths. It adds them at that working width. It then widens or truncates the sum to the destination width and hands it to the write port.

The register file sits outside the block. It has two read ports and one write port, each addressed by register number, element width and element offset. Element storage spills past the end of one register into the registers that follow it. The port reports an access that falls outside the storage through a fault input. The caller pulses `start` with the operation set up on the inputs. It then watches `busy`, and collects `done` together with `error`.

Top module: `polyAddSequencer`

## Requirements
- R1: Width codes are 0 = 64 bits (no override), 1 = 8 bits, 2 = 16 bits, 3 = 32 bits. The working width of an operation is the larger of the two source widths.
- R2: Each source is read at its own width and extended to the working width, by sign extension when `signedOp` is 1 and by zero extension otherwise. The two are added modulo 2^working width.
- R3: The sum goes to the destination width. When the destination is wider it is extended from the working width, by sign extension when `signedOp` is 1 and by zero extension otherwise. When it is narrower it is truncated. Write-data bits above the destination width are 0.
- R4: Element i produces a write only when `predMask[i]` is 1. A masked element writes nothing.
- R5: A vector-tagged register's element offset starts at 0 and rises by 1 after every element, masked ones included. A scalar register's offset stays 0. The port addresses carry the register numbers and width codes captured at start.
- R6: One element takes one cycle. `busy` is high for exactly as many cycles as elements were stepped, beginning the cycle after start is taken. `done` is a one-cycle pulse in the following cycle, with `busy` low. A `vecLen` above 64 runs 64 elements.
- R7: A `vecLen` of 0 gives `done` in the cycle after start, with no write and no `busy`.
- R8: A fault on any port during an enabled element suppresses that element's write and ends the run. `error` is high with `done` in the next cycle. `error` is low after a run that completes without a fault.
- R9: `start` has no effect while `busy` or `done` is high. The running operation keeps the settings it captured.
- R10: After reset, `busy`, `done`, `error` and `rfWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vecLen | input | 7 | Element count, 0 to 64 |
| predMask | input | 64 | Bit i enables element i |
| signedOp | input | 1 | 1 = sign extension, 0 = zero extension |
| dstReg | input | 5 | Destination register number |
| src1Reg | input | 5 | First source register number |
| src2Reg | input | 5 | Second source register number |
| dstWidth | input | 2 | Destination width code |
| src1Width | input | 2 | First source width code |
| src2Width | input | 2 | Second source width code |
| dstIsVec | input | 1 | Destination is a vector |
| src1IsVec | input | 1 | First source is a vector |
| src2IsVec | input | 1 | Second source is a vector |
| rfSrc1Reg | output | 5 | Read port 1 register number |
| rfSrc1Width | output | 2 | Read port 1 width code |
| rfSrc1Off | output | 6 | Read port 1 element offset |
| rfSrc1Data | input | 64 | Read port 1 element, right-aligned |
| rfSrc1Fault | input | 1 | Read port 1 access out of range |
| rfSrc2Reg | output | 5 | Read port 2 register number |
| rfSrc2Width | output | 2 | Read port 2 width code |
| rfSrc2Off | output | 6 | Read port 2 element offset |
| rfSrc2Data | input | 64 | Read port 2 element, right-aligned |
| rfSrc2Fault | input | 1 | Read port 2 access out of range |
| rfDstReg | output | 5 | Write port register number |
| rfDstWidth | output | 2 | Write port width code |
| rfDstOff | output | 6 | Write port element offset |
| rfWrEn | output | 1 | Write the element at the next clock edge |
| rfWrData | output | 64 | Write element, right-aligned |
| rfDstFault | input | 1 | Write port access out of range |
| busy | output | 1 | Elements are being stepped |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Run ended on a fault (valid with done) |

## Verification
The assertions assume the register-file port behaves combinationally. Read data and fault flags must depend only on the address, width and offset shown in the same cycle, and a write must land at the clock edge that ends the cycle in which `rfWrEn` is high. The bench keeps to this with a byte-array model. The model decodes addresses, flags overruns past the last byte, and commits writes on the edge. Random operations range over all register numbers, width codes, vector tags and signs, and over lengths up to and beyond 64. Most runs therefore reach the spill area and the storage end. Every input is changed half a cycle away from the sampling edge.

// File: rtl/polyAddPkg.sv
package polyAddPkg;

  localparam int XLEN = 64;
  localparam int RANK_W = 2;

  typedef enum logic [1:0] {
    WC_FULL = 2'd0,
    WC_BYTE = 2'd1,
    WC_HALF = 2'd2,
    WC_WORD = 2'd3
  } widthCode_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture operand settings
    logic elemLive;  // current element is enabled by the mask
    logic commit;    // write the current element
  } seqStrobe_t;

  // rank 0..3 stands for 8,16,32,64 bits
  function automatic logic [RANK_W-1:0] rankOf(input logic [1:0] code);
    case (widthCode_t'(code))
      WC_BYTE: rankOf = 2'd0;
      WC_HALF: rankOf = 2'd1;
      WC_WORD: rankOf = 2'd2;
      default: rankOf = 2'd3;
    endcase
  endfunction

  function automatic int unsigned rankBits(input logic [RANK_W-1:0] r);
    rankBits = 32'd8 << r;
  endfunction

  // take the low bits of v at fromRank, extend to full width, keep toRank bits
  function automatic logic [XLEN-1:0] fitWidth(input logic [XLEN-1:0] v,
                                               input logic [RANK_W-1:0] fromRank,
                                               input logic [RANK_W-1:0] toRank,
                                               input logic sgn);
    logic [XLEN-1:0] full;
    logic fill;
    int unsigned fromBits;
    int unsigned toBits;
    fromBits = rankBits(fromRank);
    toBits = rankBits(toRank);
    fill = sgn & v[fromBits-1];
    for (int k = 0; k < XLEN; k++) begin
      full[k] = (k < int'(fromBits)) ? v[k] : fill;
    end
    for (int k = 0; k < XLEN; k++) begin
      fitWidth[k] = (k < int'(toBits)) ? full[k] : 1'b0;
    end
  endfunction

endpackage

// File: rtl/seqControl.sv
module seqControl
  import polyAddPkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int LEN_W = $clog2(MAX_VL + 1),
  localparam int OFF_W = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic             dstIsVec,
  input  logic             src1IsVec,
  input  logic             src2IsVec,
  input  logic             anyFault,
  output seqStrobe_t       strobe,
  output logic [OFF_W-1:0] dstOff,
  output logic [OFF_W-1:0] src1Off,
  output logic [OFF_W-1:0] src2Off,
  output logic             busy,
  output logic             done,
  output logic             error
);

  seqState_t state;
  logic [LEN_W-1:0] vlQ;
  logic [MAX_VL-1:0] maskQ;
  logic [OFF_W-1:0] elemIdx;
  logic dstVecQ, src1VecQ, src2VecQ, errQ;
  logic [LEN_W-1:0] vlEff;
  logic elemLive, faultHit, lastElem;

  always_comb begin
    vlEff = (vecLen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vecLen;
    elemLive = (state == S_RUN) && maskQ[elemIdx];
    faultHit = elemLive && anyFault;
    lastElem = (LEN_W'(elemIdx) + LEN_W'(1)) == vlQ;
    strobe.loadCfg = (state == S_IDLE) && start;
    strobe.elemLive = elemLive;
    strobe.commit = elemLive && !anyFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      vlQ <= '0;
      maskQ <= '0;
      elemIdx <= '0;
      dstOff <= '0;
      src1Off <= '0;
      src2Off <= '0;
      dstVecQ <= 1'b0;
      src1VecQ <= 1'b0;
      src2VecQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            vlQ <= vlEff;
            maskQ <= predMask;
            dstVecQ <= dstIsVec;
            src1VecQ <= src1IsVec;
            src2VecQ <= src2IsVec;
            elemIdx <= '0;
            dstOff <= '0;
            src1Off <= '0;
            src2Off <= '0;
            errQ <= 1'b0;
            state <= (vlEff == '0) ? S_FIN : S_RUN;
          end
        end
        S_RUN: begin
          if (faultHit) begin
            errQ <= 1'b1;
            state <= S_FIN;
          end else if (lastElem) begin
            state <= S_FIN;
          end else begin
            elemIdx <= elemIdx + 1'b1;
            if (dstVecQ) dstOff <= dstOff + 1'b1;
            if (src1VecQ) src1Off <= src1Off + 1'b1;
            if (src2VecQ) src2Off <= src2Off + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_RUN);
  assign done = (state == S_FIN);
  assign error = done && errQ;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  assert_error_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);
  assert_fault_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.elemLive && anyFault) |=> (done && error));
  assert_empty_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && start && (vecLen == '0)) |=> (done && !busy));
  assert_scalar_src1_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !src1VecQ) |-> (src1Off == '0));
  assert_vec_step_src1_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && src1VecQ) |-> (src1Off == OFF_W'($past(src1Off) + 1'b1)));

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import polyAddPkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              signedOp,
  input  logic [REG_AW-1:0] dstReg,
  input  logic [REG_AW-1:0] src1Reg,
  input  logic [REG_AW-1:0] src2Reg,
  input  logic [1:0]        dstWidth,
  input  logic [1:0]        src1Width,
  input  logic [1:0]        src2Width,
  input  logic [XLEN-1:0]   rfSrc1Data,
  input  logic [XLEN-1:0]   rfSrc2Data,
  output logic [REG_AW-1:0] rfDstReg,
  output logic [REG_AW-1:0] rfSrc1Reg,
  output logic [REG_AW-1:0] rfSrc2Reg,
  output logic [1:0]        rfDstWidth,
  output logic [1:0]        rfSrc1Width,
  output logic [1:0]        rfSrc2Width,
  output logic              rfWrEn,
  output logic [XLEN-1:0]   rfWrData
);

  logic sgnQ;
  logic [RANK_W-1:0] dRank, r1Rank, r2Rank, wRank;
  logic [XLEN-1:0] opA, opB, sum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sgnQ <= 1'b0;
      rfDstReg <= '0;
      rfSrc1Reg <= '0;
      rfSrc2Reg <= '0;
      rfDstWidth <= '0;
      rfSrc1Width <= '0;
      rfSrc2Width <= '0;
    end else if (strobe.loadCfg) begin
      sgnQ <= signedOp;
      rfDstReg <= dstReg;
      rfSrc1Reg <= src1Reg;
      rfSrc2Reg <= src2Reg;
      rfDstWidth <= dstWidth;
      rfSrc1Width <= src1Width;
      rfSrc2Width <= src2Width;
    end
  end

  always_comb begin
    dRank = rankOf(rfDstWidth);
    r1Rank = rankOf(rfSrc1Width);
    r2Rank = rankOf(rfSrc2Width);
    wRank = (r1Rank > r2Rank) ? r1Rank : r2Rank;
    opA = fitWidth(rfSrc1Data, r1Rank, wRank, sgnQ);
    opB = fitWidth(rfSrc2Data, r2Rank, wRank, sgnQ);
    sum = opA + opB;
    rfWrData = fitWidth(sum, wRank, dRank, sgnQ);
    rfWrEn = strobe.commit;
  end

  assert_byte_dst_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && (widthCode_t'(rfDstWidth) == WC_BYTE)) |-> (rfWrData[XLEN-1:8] == '0));
  assert_write_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> strobe.elemLive);

endmodule

// File: rtl/polyAddSequencer.sv
module polyAddSequencer
  import polyAddPkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int REG_AW = 5,
  localparam int LEN_W = $clog2(MAX_VL + 1),
  localparam int OFF_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              signedOp,
  input  logic [REG_AW-1:0] dstReg,
  input  logic [REG_AW-1:0] src1Reg,
  input  logic [REG_AW-1:0] src2Reg,
  input  logic [1:0]        dstWidth,
  input  logic [1:0]        src1Width,
  input  logic [1:0]        src2Width,
  input  logic              dstIsVec,
  input  logic              src1IsVec,
  input  logic              src2IsVec,
  output logic [REG_AW-1:0] rfSrc1Reg,
  output logic [1:0]        rfSrc1Width,
  output logic [OFF_W-1:0]  rfSrc1Off,
  input  logic [63:0]       rfSrc1Data,
  input  logic              rfSrc1Fault,
  output logic [REG_AW-1:0] rfSrc2Reg,
  output logic [1:0]        rfSrc2Width,
  output logic [OFF_W-1:0]  rfSrc2Off,
  input  logic [63:0]       rfSrc2Data,
  input  logic              rfSrc2Fault,
  output logic [REG_AW-1:0] rfDstReg,
  output logic [1:0]        rfDstWidth,
  output logic [OFF_W-1:0]  rfDstOff,
  output logic              rfWrEn,
  output logic [63:0]       rfWrData,
  input  logic              rfDstFault,
  output logic              busy,
  output logic              done,
  output logic              error
);

  seqStrobe_t strobe;
  logic anyFault;

  assign anyFault = rfSrc1Fault | rfSrc2Fault | rfDstFault;

  seqControl #(.MAX_VL(MAX_VL)) i_seqControl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .predMask(predMask),
    .dstIsVec(dstIsVec), .src1IsVec(src1IsVec), .src2IsVec(src2IsVec),
    .anyFault(anyFault), .strobe(strobe),
    .dstOff(rfDstOff), .src1Off(rfSrc1Off), .src2Off(rfSrc2Off),
    .busy(busy), .done(done), .error(error)
  );

  seqDatapath #(.REG_AW(REG_AW)) i_seqDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .signedOp(signedOp),
    .dstReg(dstReg), .src1Reg(src1Reg), .src2Reg(src2Reg),
    .dstWidth(dstWidth), .src1Width(src1Width), .src2Width(src2Width),
    .rfSrc1Data(rfSrc1Data), .rfSrc2Data(rfSrc2Data),
    .rfDstReg(rfDstReg), .rfSrc1Reg(rfSrc1Reg), .rfSrc2Reg(rfSrc2Reg),
    .rfDstWidth(rfDstWidth), .rfSrc1Width(rfSrc1Width), .rfSrc2Width(rfSrc2Width),
    .rfWrEn(rfWrEn), .rfWrData(rfWrData)
  );

  assert_write_in_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> busy);
  assert_no_faulty_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> !(rfSrc1Fault || rfSrc2Fault || rfDstFault));

endmodule

// File: tb/test_polyAddSequencer.sv
module test_polyAddSequencer;

  localparam int NREGS = 32;
  localparam int NBYTES = NREGS * 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [6:0] vecLen = '0;
  logic [63:0] predMask = '0;
  logic signedOp = 1'b0;
  logic [4:0] dstReg = '0, src1Reg = '0, src2Reg = '0;
  logic [1:0] dstWidth = '0, src1Width = '0, src2Width = '0;
  logic dstIsVec = 1'b0, src1IsVec = 1'b0, src2IsVec = 1'b0;
  logic [4:0] rfSrc1Reg, rfSrc2Reg, rfDstReg;
  logic [1:0] rfSrc1Width, rfSrc2Width, rfDstWidth;
  logic [5:0] rfSrc1Off, rfSrc2Off, rfDstOff;
  logic [63:0] rfSrc1Data, rfSrc2Data, rfWrData;
  logic rfSrc1Fault, rfSrc2Fault, rfDstFault, rfWrEn;
  logic busy, done, error;

  logic [7:0] mem [NBYTES];
  logic [7:0] stage [NBYTES];
  logic [7:0] expMem [NBYTES];
  logic loadAll = 1'b0;

  int checkCnt = 0;
  int failCnt = 0;

  polyAddSequencer i_polyAddSequencer (.*);

  function automatic int byteCnt(input logic [1:0] code);
    case (code)
      2'd1: byteCnt = 1;
      2'd2: byteCnt = 2;
      2'd3: byteCnt = 4;
      default: byteCnt = 8;
    endcase
  endfunction

  function automatic int addrOf(input logic [4:0] r, input logic [1:0] code, input int off);
    addrOf = int'(r) * 8 + off * byteCnt(code);
  endfunction

  function automatic logic overrun(input logic [4:0] r, input logic [1:0] code, input int off);
    overrun = (addrOf(r, code, off) + byteCnt(code)) > NBYTES;
  endfunction

  function automatic logic [63:0] memRead(input logic [4:0] r, input logic [1:0] code, input int off);
    logic [63:0] v;
    int a;
    v = '0;
    a = addrOf(r, code, off);
    for (int k = 0; k < 8; k++) begin
      if (k < byteCnt(code) && (a + k) < NBYTES) v[8*k +: 8] = mem[a + k];
    end
    memRead = v;
  endfunction

  always_comb begin
    rfSrc1Data = memRead(rfSrc1Reg, rfSrc1Width, int'(rfSrc1Off));
    rfSrc2Data = memRead(rfSrc2Reg, rfSrc2Width, int'(rfSrc2Off));
    rfSrc1Fault = overrun(rfSrc1Reg, rfSrc1Width, int'(rfSrc1Off));
    rfSrc2Fault = overrun(rfSrc2Reg, rfSrc2Width, int'(rfSrc2Off));
    rfDstFault = overrun(rfDstReg, rfDstWidth, int'(rfDstOff));
  end

  always_ff @(posedge clk) begin
    if (loadAll) begin
      for (int k = 0; k < NBYTES; k++) mem[k] <= stage[k];
    end else if (rfWrEn) begin
      for (int k = 0; k < 8; k++) begin
        if (k < byteCnt(rfDstWidth) && (addrOf(rfDstReg, rfDstWidth, int'(rfDstOff)) + k) < NBYTES)
          mem[addrOf(rfDstReg, rfDstWidth, int'(rfDstOff)) + k] <= rfWrData[8*k +: 8];
      end
    end
  end

  // width in bits from code per R1
  function automatic int bitsOf(input logic [1:0] code);
    bitsOf = 8 * byteCnt(code);
  endfunction

  function automatic logic [63:0] lowMask(input int n);
    lowMask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] resize(input logic [63:0] v, input int from, input int to, input logic sgn);
    logic [63:0] x;
    x = v & lowMask(from);
    if (sgn && x[from-1]) x = x | ~lowMask(from);
    resize = x & lowMask(to);
  endfunction

  function automatic logic [63:0] expRead(input logic [4:0] r, input logic [1:0] code, input int off);
    logic [63:0] v;
    v = '0;
    for (int k = 0; k < byteCnt(code); k++) v[8*k +: 8] = expMem[addrOf(r, code, off) + k];
    expRead = v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fillRandom();
    for (int k = 0; k < NBYTES; k++) begin
      stage[k] = 8'($urandom);
      expMem[k] = stage[k];
    end
    @(negedge clk);
    loadAll = 1'b1;
    @(negedge clk);
    loadAll = 1'b0;
  endtask

  // reference run over expMem; returns stepped elements, writes, error
  task automatic refRun(input int vl, input logic [63:0] mask, input logic sgn,
                        input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
                        input logic [1:0] wd, input logic [1:0] w1, input logic [1:0] w2,
                        input logic vd, input logic v1, input logic v2,
                        output int steps, output int writes, output logic err);
    int id, i1, i2, wBits;
    logic [63:0] a, b, s, r;
    id = 0; i1 = 0; i2 = 0;
    steps = 0; writes = 0; err = 1'b0;
    wBits = (bitsOf(w1) > bitsOf(w2)) ? bitsOf(w1) : bitsOf(w2);
    for (int i = 0; i < vl; i++) begin
      steps = i + 1;
      if (mask[i]) begin
        if (overrun(r1, w1, i1) || overrun(r2, w2, i2) || overrun(rd, wd, id)) begin
          err = 1'b1;
          break;
        end
        a = resize(expRead(r1, w1, i1), bitsOf(w1), wBits, sgn);
        b = resize(expRead(r2, w2, i2), bitsOf(w2), wBits, sgn);
        s = (a + b) & lowMask(wBits);
        r = resize(s, wBits, bitsOf(wd), sgn);
        for (int k = 0; k < byteCnt(wd); k++) expMem[addrOf(rd, wd, id) + k] = r[8*k +: 8];
        writes++;
      end
      if (vd) id++;
      if (v1) i1++;
      if (v2) i2++;
    end
  endtask

  task automatic runOp(input int vlIn, input logic [63:0] mask, input logic sgn,
                       input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
                       input logic [1:0] wd, input logic [1:0] w1, input logic [1:0] w2,
                       input logic vd, input logic v1, input logic v2,
                       input bit disturb, input string tag);
    int vlEff, expSteps, expWrites, steps, writes, guard, mism;
    logic expErr;
    vlEff = (vlIn > 64) ? 64 : vlIn;
    refRun(vlEff, mask, sgn, rd, r1, r2, wd, w1, w2, vd, v1, v2, expSteps, expWrites, expErr);
    @(negedge clk);
    start = 1'b1; vecLen = 7'(vlIn); predMask = mask; signedOp = sgn;
    dstReg = rd; src1Reg = r1; src2Reg = r2;
    dstWidth = wd; src1Width = w1; src2Width = w2;
    dstIsVec = vd; src1IsVec = v1; src2IsVec = v2;
    @(negedge clk);
    start = 1'b0;
    check(busy == (vlEff > 0), "R6", {tag, " busy after start"}, 64'(busy), 64'(vlEff > 0));
    if (vlEff == 0) check(done == 1'b1, "R7", {tag, " empty run done"}, 64'(done), 64'd1);
    steps = 0; writes = 0; guard = 0;
    while (!done && guard < 200) begin
      if (busy) steps++;
      if (rfWrEn) writes++;
      if (disturb && guard == 1) begin
        start = 1'b1; vecLen = 7'd3; dstReg = 5'd0; src1Reg = 5'd0; src2Reg = 5'd0;
        dstIsVec = 1'b1; predMask = '1; signedOp = ~sgn; dstWidth = 2'd1;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R6", {tag, " done reached"}, 64'(done), 64'd1);
    check(busy == 1'b0, "R6", {tag, " busy low at done"}, 64'(busy), 64'd0);
    check(steps == expSteps, "R6", {tag, " busy cycles"}, 64'(steps), 64'(expSteps));
    check(writes == expWrites, "R4", {tag, " write count"}, 64'(writes), 64'(expWrites));
    check(error == expErr, "R8", {tag, " error flag"}, 64'(error), 64'(expErr));
    mism = 0;
    for (int k = 0; k < NBYTES; k++) if (mem[k] !== expMem[k]) mism++;
    check(mism == 0, "R2", {tag, " register contents (R3 R5)"}, 64'(mism), 64'd0);
    // start held during the done cycle must be ignored (R9)
    start = 1'b1;
    vecLen = 7'd5;
    @(negedge clk);
    start = 1'b0;
    check(!done && !busy, "R9", {tag, " start during done ignored"},
          64'({done, busy}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [63:0] got;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !rfWrEn, "R10", "reset outputs",
          64'({busy, done, error, rfWrEn}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 directed: byte -128 plus half 1, signed, into 64-bit
    fillRandom();
    stage[8] = 8'h80; expMem[8] = 8'h80;
    stage[16] = 8'h01; stage[17] = 8'h00; expMem[16] = 8'h01; expMem[17] = 8'h00;
    @(negedge clk); loadAll = 1'b1; @(negedge clk); loadAll = 1'b0;
    runOp(1, 64'h1, 1'b1, 5'd3, 5'd1, 5'd2, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "signed widen");
    got = '0;
    for (int k = 0; k < 8; k++) got[8*k +: 8] = mem[24 + k];
    check(got == 64'hFFFF_FFFF_FFFF_FF81, "R3", "signed sum to 64 bits", got, 64'hFFFF_FFFF_FFFF_FF81);
    // R2 R3 unsigned: 0x80 + 1 at 16 bits, truncated to 8
    runOp(1, 64'h1, 1'b0, 5'd4, 5'd1, 5'd2, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "unsigned trunc");
    check(mem[32] == 8'h81 && mem[33] == expMem[33], "R3", "unsigned truncate to byte",
          64'({mem[33], mem[32]}), 64'({expMem[33], 8'h81}));

    // R7 empty run
    runOp(0, '1, 1'b0, 5'd1, 5'd2, 5'd3, 2'd1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R7 vl0");
    // R4 mask all zero
    fillRandom();
    runOp(10, '0, 1'b0, 5'd1, 5'd2, 5'd3, 2'd2, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R4 no mask");
    // R5 scalar sources, vector destination, spill across registers
    runOp(20, 64'hA5A5_F00F_1234_FFFF, 1'b1, 5'd5, 5'd9, 5'd10, 2'd1, 2'd3, 2'd2,
          1'b1, 1'b0, 1'b0, 1'b0, "R5 scalar src");
    // R6 full length and clamp above 64
    fillRandom();
    runOp(64, '1, 1'b0, 5'd0, 5'd8, 5'd16, 2'd1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R6 full");
    runOp(100, '1, 1'b1, 5'd0, 5'd8, 5'd16, 2'd1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R6 clamp");
    // R8 destination overruns storage at element 1
    runOp(3, '1, 1'b0, 5'd31, 5'd1, 5'd2, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 fault");
    // R8 fault on a masked element is not a fault
    runOp(3, 64'h1, 1'b0, 5'd31, 5'd1, 5'd2, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 masked");
    // R9 start during busy
    fillRandom();
    runOp(12, 64'hFFF, 1'b1, 5'd6, 5'd7, 5'd8, 2'd2, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, "R9 busy start");

    // R1 random mix of widths, tags, masks and lengths
    for (int t = 0; t < 60; t++) begin
      if (t % 6 == 0) fillRandom();
      runOp(int'($urandom_range(0, 70)), {$urandom, $urandom}, 1'($urandom),
            5'($urandom), 5'($urandom), 5'($urandom),
            2'($urandom), 2'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), bit'($urandom_range(0, 3) == 0), "R1 random");
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule